// File: doc/BRIEF.md
# Infrared Carrier Waveform Generator

This block produces a square-ish modulation carrier on a single output line. The high and low phases are programmed independently. Each phase is measured in prescaled ticks, and a 6-bit setting of `N` gives `N + 1` ticks. An internal divider chain makes the tick from the input clock. A 4-bit select picks a power-of-two division from 1 up to 16384, and one code is reserved to mean "no tick".

An enable input gates the whole block. While enable is low, the divider and the phase counter stay cleared and the carrier stays low. Once enable is raised, the first tick starts a high phase at count 0, and from then on the high and low phases alternate without end. New phase lengths are picked up only when a phase begins, so a phase that is already running is never stretched or cut short.

The phase sequencer has three named states:
- `ST_OFF`: idle, carrier low.
- `ST_HIGH`: high phase.
- `ST_LOW`: low phase.

Its transitions are:
- `ST_OFF -> ST_HIGH` on a tick while enabled.
- `ST_HIGH -> ST_LOW` on a tick when the count equals the latched high length.
- `ST_LOW -> ST_HIGH` on a tick when the count equals the latched low length.
- any state `-> ST_OFF` when enable is low.

On every other tick the phase count increments and the state stays the same.

Top module: `ir_carrier_gen`

## Requirements
- R1: After reset, `carrier_o` is 0.
- R2: With `div_sel_i` = k for k in 0..14, one tick occurs every 2^k clock cycles. Code 0x0 divides by 1 and each higher code doubles the divisor. The select is 4 bits with 0x0 as its intended default.
- R3: A high length setting H (6 bits, 0..63) makes each high phase last (H+1) ticks, i.e. (H+1)·2^k clock cycles.
- R4: A low length setting L (6 bits, 0..63) makes each low phase last (L+1) ticks, i.e. (L+1)·2^k clock cycles.
- R5: After `enable_i` is first sampled high, `carrier_o` goes high 2^k cycles later, counting that first sampling edge as cycle 1. The waveform begins with a full high phase at count 0.
- R6: When `enable_i` is sampled low, `carrier_o` is 0 after that clock edge, and the divider and the phase count are cleared. A later enable starts again per R5 with a full high phase.
- R7: Select code 0xf is reserved and produces no tick. While it is applied, `carrier_o` keeps its current level.
- R8: A change to the high or low length during a phase does not alter that phase. It takes effect from the next phase of that kind.
- R9: While enabled, `carrier_o` changes only on a clock edge at which a tick occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Run gate; low clears the block and forces the carrier low |
| div_sel_i | input | 4 | Tick division select: 2^code for codes 0..14; 0xf means no tick |
| high_len_i | input | 6 | High phase length minus one, in ticks |
| low_len_i | input | 6 | Low phase length minus one, in ticks |
| carrier_o | output | 1 | Carrier waveform |

## Verification
The main function is exercised with several combinations of division code, high length and low length:
- Balanced lengths, unbalanced lengths and the 63/63 extreme show whether the two phase counters are kept apart and whether the plus-one encoding is right at both ends.
- Division codes 0, 1, 2, 3, 5 and 14 show whether the tick period scales by exact powers of two rather than by an off-by-one multiple.
- The enable-to-first-high delay tells a tick-aligned start from a free-running one.

Directed runs then cover three further cases:
- Rewriting a length mid-phase separates boundary-latched settings from live ones.
- Applying the reserved code while high checks that the level is frozen.
- Dropping enable mid-phase and re-enabling confirms that the count is cleared rather than resumed.

// File: rtl/ircar_pkg.sv
package ircar_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } phase_state_t;

endpackage

// File: rtl/ircar_prescaler.sv
module ircar_prescaler #(
    parameter int SEL_W = 4,
    parameter int DIV_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] sel_mask;
    logic             sel_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (!run_i) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    // Mask of the low sel bits; a tick fires when they are all ones.
    always_comb begin
        sel_mask = '0;
        for (int i = 0; i < DIV_W; i++) begin
            sel_mask[i] = (i < int'(sel_i));
        end
    end

    assign sel_valid = (int'(sel_i) <= DIV_W);
    assign tick_o    = run_i && sel_valid && ((div_cnt & sel_mask) == sel_mask);

    // R2
    sel_zero_every_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && sel_i == '0) |-> tick_o);

    // R6
    cleared_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (div_cnt == '0));

endmodule

// File: rtl/ircar_phase_fsm.sv
module ircar_phase_fsm
    import ircar_pkg::*;
#(
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             tick_i,
    input  logic [LEN_W-1:0] high_len_i,
    input  logic [LEN_W-1:0] low_len_i,
    output logic             carrier_o
);

    phase_state_t     state_q, state_d;
    logic [LEN_W-1:0] cnt_q, cnt_d;
    logic [LEN_W-1:0] len_q, len_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
            len_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            len_q   <= len_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        len_d   = len_q;
        if (!enable_i) begin
            state_d = ST_OFF;
            cnt_d   = '0;
            len_d   = '0;
        end else if (tick_i) begin
            unique case (state_q)
                ST_OFF: begin
                    state_d = ST_HIGH;
                    cnt_d   = '0;
                    len_d   = high_len_i;
                end
                ST_HIGH: begin
                    if (cnt_q == len_q) begin
                        state_d = ST_LOW;
                        cnt_d   = '0;
                        len_d   = low_len_i;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_LOW: begin
                    if (cnt_q == len_q) begin
                        state_d = ST_HIGH;
                        cnt_d   = '0;
                        len_d   = high_len_i;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_d = ST_OFF;
                    cnt_d   = '0;
                    len_d   = '0;
                end
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            carrier_o <= 1'b0;
        end else begin
            carrier_o <= (state_d == ST_HIGH);
        end
    end

    // R3 R4
    count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= len_q);

    // R6
    disable_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (!carrier_o && state_q == ST_OFF && cnt_q == '0));

    // R8
    length_held_in_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && state_q != ST_OFF && $stable(state_q)) |-> $stable(len_q));

    // R5
    start_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && enable_i && tick_i) |=> (state_q == ST_HIGH && cnt_q == '0));

endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen #(
    parameter int SEL_W = 4,
    parameter int DIV_W = 14,
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic [SEL_W-1:0] div_sel_i,
    input  logic [LEN_W-1:0] high_len_i,
    input  logic [LEN_W-1:0] low_len_i,
    output logic             carrier_o
);

    localparam logic [SEL_W-1:0] SEL_NONE = SEL_W'(DIV_W + 1);

    logic tick;

    ircar_prescaler #(
        .SEL_W (SEL_W),
        .DIV_W (DIV_W)
    ) presc_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (enable_i),
        .sel_i  (div_sel_i),
        .tick_o (tick)
    );

    ircar_phase_fsm #(
        .LEN_W (LEN_W)
    ) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (enable_i),
        .tick_i     (tick),
        .high_len_i (high_len_i),
        .low_len_i  (low_len_i),
        .carrier_o  (carrier_o)
    );

    // R7
    reserved_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && div_sel_i == SEL_NONE) |=> $stable(carrier_o));

    // R9
    change_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && !tick) |=> $stable(carrier_o));

    // R1
    reset_low_chk: assert property (@(posedge clk)
        !rst_n |-> !carrier_o);

endmodule

// File: tb/ir_carrier_gen_tb.sv
module ir_carrier_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable_i = 1'b0;
    logic [3:0] div_sel_i = 4'd0;
    logic [5:0] high_len_i = 6'd0;
    logic [5:0] low_len_i = 6'd0;
    logic       carrier_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    ir_carrier_gen dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (enable_i),
        .div_sel_i  (div_sel_i),
        .high_len_i (high_len_i),
        .low_len_i  (low_len_i),
        .carrier_o  (carrier_o)
    );

    // {sel, high, low}
    localparam int NVEC = 7;
    localparam logic [15:0] VEC [NVEC] = '{
        {4'd0,  6'd2,  6'd1},
        {4'd1,  6'd0,  6'd0},
        {4'd2,  6'd5,  6'd3},
        {4'd3,  6'd1,  6'd4},
        {4'd0,  6'd63, 6'd63},
        {4'd5,  6'd0,  6'd2},
        {4'd14, 6'd0,  6'd0}
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // count consecutive negedge samples at level lvl, starting now
    task automatic run_len(input logic lvl, output int n);
        n = 0;
        while (carrier_o == lvl && n < 100000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic start_and_wait(output int lows);
        enable_i = 1'b1;
        lows = 0;
        @(negedge clk);
        while (!carrier_o && lows < 100000) begin
            lows++;
            @(negedge clk);
        end
    endtask

    task automatic stop();
        enable_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        int lows, hn, ln;
        repeat (3) @(negedge clk);
        check("R1 reset carrier", int'(carrier_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle carrier", int'(carrier_o), 0);

        // R2 R3 R4 R5 table walk
        for (int v = 0; v < NVEC; v++) begin
            int k, h, l;
            k = int'(VEC[v][15:12]);
            h = int'(VEC[v][11:6]);
            l = int'(VEC[v][5:0]);
            div_sel_i  = VEC[v][15:12];
            high_len_i = VEC[v][11:6];
            low_len_i  = VEC[v][5:0];
            start_and_wait(lows);
            check("R5 start delay", lows, (1 << k) - 1);
            run_len(1'b1, hn);
            check("R3 high length", hn, (h + 1) << k);
            run_len(1'b0, ln);
            check("R4 low length", ln, (l + 1) << k);
            run_len(1'b1, hn);
            check("R2 repeat high", hn, (h + 1) << k);
            stop();
        end

        // R8: mid-phase length change
        div_sel_i = 4'd0; high_len_i = 6'd10; low_len_i = 6'd3;
        start_and_wait(lows);
        repeat (3) @(negedge clk);
        high_len_i = 6'd2;
        run_len(1'b1, hn);
        check("R8 running high kept", hn + 3, 11);
        low_len_i = 6'd7;
        run_len(1'b0, ln);
        check("R8 running low kept", ln, 4);
        run_len(1'b1, hn);
        check("R8 new high applied", hn, 3);
        run_len(1'b0, ln);
        check("R8 new low applied", ln, 8);

        // R7: reserved code freezes level (carrier now high)
        high_len_i = 6'd20;
        run_len(1'b1, hn);
        run_len(1'b0, ln);
        repeat (2) @(negedge clk);
        div_sel_i = 4'hf;
        begin
            int changed;
            changed = 0;
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                if (carrier_o != 1'b1) changed++;
            end
            check("R7 reserved holds high", changed, 0);
        end

        // R6: disable forces low and clears count
        enable_i = 1'b0;
        @(negedge clk);
        check("R6 forced low", int'(carrier_o), 0);
        div_sel_i = 4'd0; high_len_i = 6'd4; low_len_i = 6'd1;
        start_and_wait(lows);
        check("R6 restart delay", lows, 0);
        repeat (2) @(negedge clk);
        enable_i = 1'b0;
        @(negedge clk);
        check("R6 low mid-phase", int'(carrier_o), 0);
        start_and_wait(lows);
        run_len(1'b1, hn);
        check("R6 full high after restart", hn, 5);

        // R9: divide-by-4 edges only on tick spacing
        stop();
        div_sel_i = 4'd2; high_len_i = 6'd0; low_len_i = 6'd0;
        start_and_wait(lows);
        run_len(1'b1, hn);
        check("R9 high on tick grid", hn, 4);
        stop();

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule